// File: doc/BRIEF.md
# Lowercasing String Copy Engine

This engine copies a zero-terminated byte string from one place in memory to another. It folds uppercase ASCII letters to lowercase on the way. A one-cycle start pulse supplies a source address and a destination address. The engine then runs the transfer through a single-port byte memory port that has separate read and write strobes and a read-valid return. For each byte it issues one read at the current source address and waits for the returned data. It adjusts the case of that data and writes it to the current destination address. Both pointers then advance by one.

The terminating zero byte is copied too. The engine writes it to the destination first, and only then does the transfer finish. Source and destination share one flat, 16-bit address space that wraps from the top address back to zero. While a copy runs, the engine holds a busy flag high. In the cycle after the terminator has been written, it emits a single-cycle done pulse.

Top module: `lcase_copy_engine`

## Requirements
- R1: Each byte takes exactly one read strobe followed by exactly one write strobe. Each strobe lasts one cycle, and read and write are never high in the same cycle.
- R2: A byte in the range 0x41 to 0x5A inclusive is written as the byte plus 0x20. Every other byte value (for example 0x40, 0x5B, 0x61, 0x7F, 0x80, 0xFF) is written unchanged.
- R3: A byte of value 0x00 is written to the destination, and the copy ends after that write. No further read or write strobe follows until a new start is accepted.
- R4: Byte k of a copy (counting from 0) is read at source address + k and written at destination address + k.
- R5: Addresses are 16 bits wide and wrap modulo 2^16, so the address after 0xFFFF is 0x0000.
- R6: A start pulse that arrives while a copy is running has no effect. The running copy keeps its original addresses and its data.
- R7: After a start is accepted in cycle 0, busy is high from cycle 1 up to and including the last cycle before done. Busy is low in the done cycle.
- R8: Done is high for exactly one cycle, in the cycle right after the cycle that carries the terminator's write strobe.
- R9: The write strobe comes in the cycle after read-valid is seen. If read-valid is late, the engine waits for it, so each byte costs 3 + L cycles, where L is the number of extra wait cycles of the memory.
- R10: During reset and right after it, the read strobe, write strobe, busy, done and memory address are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a copy; ignored while busy |
| src_addr_i | input | 16 | Address of the first source byte, sampled with start |
| dst_addr_i | input | 16 | Address of the first destination byte, sampled with start |
| mem_addr_o | output | 16 | Memory address for the current read or write |
| mem_rd_o | output | 1 | Read strobe, one cycle per byte |
| mem_wr_o | output | 1 | Write strobe, one cycle per byte |
| mem_wdata_o | output | 8 | Case-folded byte to write |
| mem_rdata_i | input | 8 | Read data from memory |
| mem_rvalid_i | input | 1 | Read data valid |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle pulse after the terminator write |

## Verification
The bench samples on the falling edge and counts falling edges from the cycle in which start is sampled. With a memory that has L extra wait cycles, done appears on falling edge (3 + L)·n + 1 for an n-byte string including the terminator. At that edge the bench also expects busy to be low, and one edge later it expects done to be low again. A monitor on the rising edges records every read and write strobe with its address and data. Each run then checks the read addresses, the write addresses and the folded data against values worked out from the source bytes. It also checks that no write came without read-valid in the cycle before, and that no strobe appears in the idle cycles after done.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_WRITE = 2'd2
  } lcc_state_e;
endpackage

// File: rtl/lcc_ptr.sv
module lcc_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)         ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (step_i) ptr_q <= ptr_q + ONE;
  end

  assign ptr_o = ptr_q;

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> (ptr_o == $past(ptr_o) + ONE));
endmodule

// File: rtl/lcc_fold.sv
module lcc_fold #(
  parameter int            DW    = 8,
  parameter logic [DW-1:0] LO    = 8'h41,
  parameter logic [DW-1:0] HI    = 8'h5A,
  parameter logic [DW-1:0] DELTA = 8'h20
) (
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] byte_o,
  output logic          zero_o
);
  logic in_range;

  always_comb begin
    in_range = (byte_i >= LO) && (byte_i <= HI);
    byte_o   = in_range ? (byte_i + DELTA) : byte_i;
    zero_o   = (byte_i == '0);
  end
endmodule

// File: rtl/lcc_seq.sv
module lcc_seq
  import lcc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic rvalid_i,
  input  logic zero_i,
  output logic ev_start_o,
  output logic ev_fetch_o,
  output logic ev_next_o,
  output logic rd_o,
  output logic wr_o,
  output logic busy_o,
  output logic done_o
);
  lcc_state_e state_q;
  logic       term_q;

  always_comb begin
    ev_start_o = (state_q == ST_IDLE)  && start_i;
    ev_fetch_o = (state_q == ST_WAIT)  && rvalid_i;
    ev_next_o  = (state_q == ST_WRITE) && !term_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      term_q  <= 1'b0;
      rd_o    <= 1'b0;
      wr_o    <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      rd_o   <= 1'b0;
      wr_o   <= 1'b0;
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WAIT;
          rd_o    <= 1'b1;
          busy_o  <= 1'b1;
        end
        ST_WAIT: if (rvalid_i) begin
          state_q <= ST_WRITE;
          wr_o    <= 1'b1;
          term_q  <= zero_i;
        end
        ST_WRITE: begin
          if (term_q) begin
            state_q <= ST_IDLE;
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
          end else begin
            state_q <= ST_WAIT;
            rd_o    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst) !(rd_o && wr_o));
  // R1
  rd_single_chk: assert property (@(posedge clk) disable iff (rst) rd_o |=> !rd_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o);
  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst) done_o |-> !busy_o);
  // R9
  wr_after_valid_chk: assert property (@(posedge clk) disable iff (rst) $rose(wr_o) |-> $past(rvalid_i));
endmodule

// File: rtl/lcase_copy_engine.sv
module lcase_copy_engine #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_rvalid_i,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] UP_LO = DW'(8'h41);
  localparam logic [DW-1:0] UP_HI = DW'(8'h5A);

  logic          ev_start, ev_fetch, ev_next, zero_b;
  logic [AW-1:0] src_ptr, dst_ptr;
  logic [DW-1:0] folded;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  lcc_seq u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .rvalid_i(mem_rvalid_i),
    .zero_i(zero_b), .ev_start_o(ev_start), .ev_fetch_o(ev_fetch),
    .ev_next_o(ev_next), .rd_o(mem_rd_o), .wr_o(mem_wr_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  lcc_ptr #(.AW(AW)) u_src_ptr (
    .clk(clk), .rst(rst), .load_i(ev_start), .load_val_i(src_addr_i),
    .step_i(ev_next), .ptr_o(src_ptr)
  );

  lcc_ptr #(.AW(AW)) u_dst_ptr (
    .clk(clk), .rst(rst), .load_i(ev_start), .load_val_i(dst_addr_i),
    .step_i(ev_next), .ptr_o(dst_ptr)
  );

  lcc_fold #(.DW(DW), .LO(UP_LO), .HI(UP_HI), .DELTA(DW'(8'h20))) u_fold (
    .byte_i(mem_rdata_i), .byte_o(folded), .zero_o(zero_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (ev_start) begin
      addr_q  <= src_addr_i;
    end else if (ev_fetch) begin
      addr_q  <= dst_ptr;
      wdata_q <= folded;
    end else if (ev_next) begin
      addr_q  <= src_ptr + ONE;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  // R2
  no_upper_out_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> !((mem_wdata_o >= UP_LO) && (mem_wdata_o <= UP_HI)));
  // R3
  term_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_o && mem_wdata_o == '0) |=> done_o);
endmodule

// File: tb/lcase_copy_engine_test.sv
module lcase_copy_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] src_addr_i = '0, dst_addr_i = '0;
  logic [15:0] mem_addr_o;
  logic        mem_rd_o, mem_wr_o, busy_o, done_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        mem_rvalid_i = 1'b0;

  int checks = 0, errors = 0, wd = 0;
  int lat = 0;
  logic [7:0]  mem [0:4095];
  logic [7:0]  sbuf [0:31];
  int          slen;
  logic [15:0] rd_log [0:63];
  logic [15:0] wa_log [0:63];
  logic [7:0]  wd_log [0:63];
  int rd_n = 0, wr_n = 0, viol = 0;
  logic prev_rv = 1'b0;
  logic pend = 1'b0;
  int pcnt = 0;
  logic [7:0] hold = '0;

  lcase_copy_engine uut (
    .clk(clk), .rst(rst), .start_i(start_i), .src_addr_i(src_addr_i),
    .dst_addr_i(dst_addr_i), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_rvalid_i(mem_rvalid_i), .busy_o(busy_o), .done_o(done_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    mem_rvalid_i <= 1'b0;
    if (!rst) begin
      if (mem_wr_o && !prev_rv) viol++;
      prev_rv = mem_rvalid_i;
      if (mem_wr_o) begin
        mem[mem_addr_o[11:0]] = mem_wdata_o;
        if (wr_n < 64) begin wa_log[wr_n] = mem_addr_o; wd_log[wr_n] = mem_wdata_o; end
        wr_n++;
      end
      if (mem_rd_o) begin
        if (rd_n < 64) rd_log[rd_n] = mem_addr_o;
        rd_n++;
        if (lat == 0) begin
          mem_rvalid_i <= 1'b1;
          mem_rdata_i  <= mem[mem_addr_o[11:0]];
        end else begin
          pend = 1'b1; pcnt = lat - 1; hold = mem[mem_addr_o[11:0]];
        end
      end else if (pend) begin
        if (pcnt == 0) begin
          mem_rvalid_i <= 1'b1; mem_rdata_i <= hold; pend = 1'b0;
        end else pcnt--;
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] exp_fold(input logic [7:0] b);
    return (b >= 8'h41 && b <= 8'h5A) ? b + 8'h20 : b;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_str(input string s);
    for (int i = 0; i < s.len(); i++) sbuf[i] = s[i];
    sbuf[s.len()] = 8'h00;
    slen = s.len() + 1;
  endtask

  task automatic run_copy(input logic [15:0] src, input logic [15:0] dst,
                          input int l, input int intrude);
    int cyc, exp_cyc, busy_bad;
    bit ok;
    lat = l;
    for (int k = 0; k < slen; k++) mem[12'(src + 16'(k))] = sbuf[k];
    rd_n = 0; wr_n = 0; viol = 0; busy_bad = 0;
    @(negedge clk);
    start_i = 1'b1; src_addr_i = src; dst_addr_i = dst;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    exp_cyc = (3 + l) * slen + 1;
    while (!done_o && cyc < 2000) begin
      if (!busy_o) busy_bad++;
      if (cyc == intrude) begin
        start_i = 1'b1; src_addr_i = 16'h0300; dst_addr_i = 16'h0400;
      end else start_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(cyc == exp_cyc, "R9", "done cycle", cyc, exp_cyc);
    chk(busy_bad == 0, "R7", "busy low during copy", busy_bad, 0);
    chk(!busy_o, "R7", "busy in done cycle", busy_o, 0);
    chk(rd_n == slen, "R1", "read count", rd_n, slen);
    chk(wr_n == slen, "R3", "write count", wr_n, slen);
    chk(viol == 0, "R9", "write without prior valid", viol, 0);
    for (int k = 0; k < slen && k < 64; k++) begin
      chk(rd_log[k] == 16'(src + 16'(k)), "R4", "read addr", rd_log[k], 16'(src + 16'(k)));
      chk(wa_log[k] == 16'(dst + 16'(k)), "R4", "write addr", wa_log[k], 16'(dst + 16'(k)));
      chk(wd_log[k] == exp_fold(sbuf[k]), "R2", "write data", wd_log[k], exp_fold(sbuf[k]));
    end
    ok = (wd_log[slen-1] == 8'h00);
    chk(ok, "R3", "terminator written", wd_log[slen-1], 0);
    @(negedge clk);
    chk(!done_o, "R8", "done width", done_o, 0);
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk(rd_n == slen && wr_n == slen, "R3", "no access after end", rd_n + wr_n, 2 * slen);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!mem_rd_o && !mem_wr_o, "R10", "strobes in reset", {mem_rd_o, mem_wr_o}, 0);
    chk(!busy_o && !done_o, "R10", "busy/done in reset", {busy_o, done_o}, 0);
    chk(mem_addr_o == 16'h0, "R10", "addr in reset", mem_addr_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !mem_rd_o && !mem_wr_o, "R10", "after reset",
        {busy_o, done_o, mem_rd_o, mem_wr_o}, 0);
  endtask

  task automatic t_mixed;
    set_str("AZ@[`az{Hi, M0!");
    run_copy(16'h0100, 16'h0200, 0, 0);
  endtask

  task automatic t_empty;
    set_str("");
    run_copy(16'h0120, 16'h0220, 0, 0);
  endtask

  task automatic t_high_bytes;
    sbuf[0] = 8'h80; sbuf[1] = 8'hC1; sbuf[2] = 8'hFF; sbuf[3] = 8'h7F;
    sbuf[4] = 8'h5B; sbuf[5] = 8'h40; sbuf[6] = 8'h41; sbuf[7] = 8'h00;
    slen = 8;
    run_copy(16'h0140, 16'h0240, 2, 0);
  endtask

  task automatic t_wrap;
    set_str("WrAp");
    run_copy(16'hFFFE, 16'h0800, 1, 0);   // R5 source wraps
    set_str("QX");
    run_copy(16'h0A00, 16'hFFFF, 0, 0);   // R5 destination wraps
  endtask

  task automatic t_start_busy;
    set_str("IGNORE Me");
    mem[12'h300] = 8'h55; mem[12'h301] = 8'h00;
    run_copy(16'h0500, 16'h0600, 0, 5);   // R6 start mid-copy
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    t_reset();
    t_mixed();
    t_empty();
    t_high_bytes();
    t_wrap();
    t_start_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule